// File: doc/BRIEF.md
# Split Decade Divider Counter

A four-bit counter made of two sections that can run alone or be chained. The low section is a single toggle stage whose output is bit 0 of the count. The high section is a modulo-five stage whose three-bit binary value appears on bits 3..1. Each section has its own count line and advances when that line falls. Two pairs of AND-gated override inputs act without waiting for a clock. One pair clears the count. The other pair loads nine. The load-nine pair wins when both pairs are active.

A two-bit link selector sets how the sections connect. In the "none" setting the sections are independent, giving a divide-by-two and a divide-by-five. In the decimal setting the falling low bit steps the high section, so the low count line gives an 8421 decade count. In the split-symmetry setting the falling bit 3 steps the low section, and the high count line is the input. Bit 0 is then a square wave at one tenth of the input rate with a 50% duty cycle. Every register runs on one system clock. The count lines are sampled and their falling edges are detected. A chained step lands one system clock after the section that drives it changes.

Top module: `decade_split_counter`

## Requirements
- R1: While `rst_n` is low the count is 0, and it reads 0 right after `rst_n` falls.
- R2: The low section toggles bit 0 once for each falling edge of its step source. A rising edge of a count line leaves the count unchanged.
- R3: The high section holds a binary value on bits 3..1. It steps 0,1,2,3,4 and wraps to 0, and any value above 4 goes to 0 on its next step.
- R4: With `link_mode` 2'b00 or 2'b11 the sections are independent. A falling edge of `cnt_a_in` steps the low section, a falling edge of `cnt_b_in` steps the high section, and `cnt_out` equals 2*(falls of B mod 5) + (falls of A mod 2).
- R5: With `link_mode` 2'b01, `cnt_out` equals the number of `cnt_a_in` falling edges mod 10, encoded 8421, and `cnt_b_in` has no effect.
- R6: With `link_mode` 2'b10, after k falling edges of `cnt_b_in` (counted mod 10), `cnt_out` = 2*(k mod 5) + (k div 5). Bit 0 is high for exactly 5 of every 10 input edges, and `cnt_a_in` has no effect.
- R7: When `clr_a` and `clr_b` are both high and the set pair is not, `cnt_out` is 0 with no clock edge needed. Count edges are ignored, and the count stays 0 after release.
- R8: When `pre_a` and `pre_b` are both high, `cnt_out` is 9 (4'b1001) with no clock edge needed, whatever the clear pair does. Count edges are ignored, and the count stays 9 after release.
- R9: A single input of either override pair has no effect.
- R10: A chained step is applied exactly one system clock after the driving section changes. In decimal mode the step from 1 to 2 therefore shows 0 for one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cnt_a_in | input | 1 | Count line of the low (divide-by-two) section |
| cnt_b_in | input | 1 | Count line of the high (divide-by-five) section |
| clr_a | input | 1 | Clear pair, first input |
| clr_b | input | 1 | Clear pair, second input |
| pre_a | input | 1 | Load-nine pair, first input |
| pre_b | input | 1 | Load-nine pair, second input |
| link_mode | input | 2 | 00/11 independent, 01 decimal, 10 split-symmetry |
| cnt_out | output | 4 | Count value, bit 0 from the low section |

## Verification
The chaining checks assume that a count line stays at each level for several system clocks. A chained step then never collides with an external step, and the one-clock link delay can be observed. The checks also assume that `link_mode` does not change while a chained step is pending. If the mode changes or an override arrives in that cycle, the properties excuse it. The stimulus holds each count level for at least three clocks and changes the mode and the overrides only after the count has settled. It therefore stays within these assumptions.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
  localparam int unsigned QN_MOD = 5;
  localparam int unsigned QN_W   = $clog2(QN_MOD);
  localparam int unsigned OUT_W  = QN_W + 1;
  localparam logic [OUT_W-1:0] LOAD_VAL = OUT_W'(9);

  typedef enum logic [1:0] {
    LINK_NONE = 2'b00,
    LINK_DEC  = 2'b01,
    LINK_SYM  = 2'b10,
    LINK_ALT  = 2'b11
  } link_e;

  function automatic logic [QN_W-1:0] quin_next(input logic [QN_W-1:0] v);
    if (v >= QN_W'(QN_MOD - 1)) return '0;
    return v + 1'b1;
  endfunction

  function automatic logic [OUT_W-1:0] join_out(input logic lo, input logic [QN_W-1:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/dsc_fall_det.sv
`timescale 1ns/1ps
module dsc_fall_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[g];
    end
    assign fall[g] = prev_q & ~lvl[g];
  end
endmodule

// File: rtl/dsc_toggle.sv
`timescale 1ns/1ps
module dsc_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_val,
  input  logic step,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (load_en) q <= load_val;
    else if (step)    q <= ~q;
  end
endmodule

// File: rtl/dsc_quinary.sv
`timescale 1ns/1ps
module dsc_quinary
  import dsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [QN_W-1:0] load_val,
  input  logic            step,
  output logic [QN_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= load_val;
    else if (step)    q <= quin_next(q);
  end
endmodule

// File: rtl/decade_split_counter.sv
`timescale 1ns/1ps
module decade_split_counter
  import dsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_a_in,
  input  logic             cnt_b_in,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             pre_a,
  input  logic             pre_b,
  input  logic [1:0]       link_mode,
  output logic [OUT_W-1:0] cnt_out
);
  link_e           lm;
  logic            pre_all, clr_all, hold_all;
  logic            is_dec, is_sym;
  logic [1:0]      ext_fall;
  logic            a_tick, b_tick;
  logic            a_q;
  logic [QN_W-1:0] b_q;
  logic            link_to_b_q, link_to_a_q;
  logic            a_load;
  logic [QN_W-1:0] b_load;

  assign lm       = link_e'(link_mode);
  assign pre_all  = pre_a & pre_b;
  assign clr_all  = clr_a & clr_b;
  assign hold_all = pre_all | clr_all;
  assign is_dec   = (lm == LINK_DEC);
  assign is_sym   = (lm == LINK_SYM);

  dsc_fall_det #(.N(2)) u_fall (
    .clk(clk), .rst_n(rst_n), .lvl({cnt_b_in, cnt_a_in}), .fall(ext_fall)
  );

  // step sources, chosen by the link setting; overrides block every step
  assign a_tick = ~hold_all & (is_sym ? link_to_a_q : ext_fall[0]);
  assign b_tick = ~hold_all & (is_dec ? link_to_b_q : ext_fall[1]);

  // a section's output about to fall is turned into a step one clock later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_to_b_q <= 1'b0;
      link_to_a_q <= 1'b0;
    end else begin
      link_to_b_q <= a_tick & a_q;
      link_to_a_q <= b_tick & b_q[QN_W-1];
    end
  end

  assign a_load = pre_all ? LOAD_VAL[0] : 1'b0;
  assign b_load = pre_all ? LOAD_VAL[OUT_W-1:1] : '0;

  dsc_toggle u_lo (
    .clk(clk), .rst_n(rst_n), .load_en(hold_all), .load_val(a_load),
    .step(a_tick), .q(a_q)
  );

  dsc_quinary u_hi (
    .clk(clk), .rst_n(rst_n), .load_en(hold_all), .load_val(b_load),
    .step(b_tick), .q(b_q)
  );

  // overrides act on the output at once, without waiting for the clock
  always_comb begin
    if (pre_all)      cnt_out = LOAD_VAL;
    else if (clr_all) cnt_out = '0;
    else              cnt_out = join_out(a_q, b_q);
  end
endmodule

// File: rtl/dsc_checker.sv
`timescale 1ns/1ps
module dsc_checker
  import dsc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      link_mode,
  input logic            pre_all,
  input logic            clr_all,
  input logic            a_tick,
  input logic            b_tick,
  input logic            a_q,
  input logic [QN_W-1:0] b_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (!a_q && b_q == '0)); // R1

  AST_LO_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    a_tick |=> (a_q != $past(a_q))); // R2

  AST_HI_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    b_q <= QN_W'(QN_MOD - 1)); // R3

  AST_HI_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    b_tick |=> (b_q == quin_next($past(b_q)))); // R3

  AST_CLEAR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !pre_all) |=> (!a_q && b_q == '0)); // R7

  AST_NINE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |=> (a_q && b_q == LOAD_VAL[OUT_W-1:1])); // R8

  AST_DEC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b01 && a_tick && a_q)
      |=> (b_tick || pre_all || clr_all || link_mode != 2'b01)); // R10

  AST_SYM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b10 && b_tick && b_q[QN_W-1])
      |=> (a_tick || pre_all || clr_all || link_mode != 2'b10)); // R10
endmodule

bind decade_split_counter dsc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .link_mode(link_mode), .pre_all(pre_all),
  .clr_all(clr_all), .a_tick(a_tick), .b_tick(b_tick), .a_q(a_q), .b_q(b_q)
);

// File: tb/decade_split_counter_tb_top.sv
`timescale 1ns/1ps
module decade_split_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_a_in = 1'b0, cnt_b_in = 1'b0;
  logic       clr_a = 1'b0, clr_b = 1'b0, pre_a = 1'b0, pre_b = 1'b0;
  logic [1:0] link_mode = 2'b00;
  logic [3:0] cnt_out;
  int         n_run = 0, n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  decade_split_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_a_in(cnt_a_in), .cnt_b_in(cnt_b_in),
    .clr_a(clr_a), .clr_b(clr_b), .pre_a(pre_a), .pre_b(pre_b),
    .link_mode(link_mode), .cnt_out(cnt_out)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] want);
    n_run++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, want);
    end
  endtask

  task automatic set_line(input int sel, input logic v);
    if (sel == 0) cnt_a_in = v;
    else          cnt_b_in = v;
  endtask

  task automatic pulse(input int sel);
    set_line(sel, 1'b1);
    repeat (3) @(negedge clk);
    set_line(sel, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [3:0] indep_exp(input int na, input int nb);
    return 4'((nb % 5) * 2 + (na % 2));
  endfunction

  function automatic logic [3:0] sym_exp(input int k);
    int m;
    m = k % 10;
    return 4'((m % 5) * 2 + (m / 5));
  endfunction

  initial begin
    int na, nb, n, hi;
    repeat (3) @(negedge clk);
    chk("R1 reset value", cnt_out, 4'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // independent sections
    na = 0; nb = 0;
    for (int i = 0; i < 14; i++) begin
      if (i % 3 != 2) begin pulse(0); na++; end
      if (i % 2 == 0) begin pulse(1); nb++; end
      chk("R4 R3 independent count", cnt_out, indep_exp(na, nb));
    end
    set_line(0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2 rising edge ignored", cnt_out, indep_exp(na, nb));
    set_line(0, 1'b0);
    repeat (4) @(negedge clk);
    na++;
    chk("R2 falling edge toggles", cnt_out, indep_exp(na, nb));
    link_mode = 2'b11;
    for (int i = 0; i < 4; i++) begin
      pulse(1); nb++;
      if (i % 2 == 1) begin pulse(0); na++; end
      chk("R4 code 11 independent", cnt_out, indep_exp(na, nb));
    end

    // clear pair
    clr_a = 1'b1;
    #1 chk("R9 single clear input", cnt_out, indep_exp(na, nb));
    clr_b = 1'b1;
    #1 chk("R7 clear acts at once", cnt_out, 4'd0);
    @(negedge clk);
    pulse(0); pulse(1);
    chk("R7 edges ignored in clear", cnt_out, 4'd0);
    clr_a = 1'b0; clr_b = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 zero after release", cnt_out, 4'd0);

    // decimal link
    link_mode = 2'b01;
    pulse(0); n = 1;
    chk("R5 decimal count", cnt_out, 4'd1);
    set_line(0, 1'b1);
    repeat (3) @(negedge clk);
    set_line(0, 1'b0);
    @(negedge clk);
    chk("R10 low bit falls first", cnt_out, 4'd0);
    @(negedge clk);
    chk("R10 high step one clock later", cnt_out, 4'd2);
    repeat (3) @(negedge clk);
    n = 2;
    for (int i = 0; i < 22; i++) begin
      pulse(0); n++;
      chk("R5 decimal count", cnt_out, 4'(n % 10));
    end
    pulse(1);
    chk("R5 cnt_b_in ignored", cnt_out, 4'(n % 10));
    pre_a = 1'b1;
    pulse(0); n++;
    chk("R9 single set input", cnt_out, 4'(n % 10));
    pre_a = 1'b0; clr_b = 1'b1;
    pulse(0); n++;
    chk("R9 single clear input", cnt_out, 4'(n % 10));
    clr_b = 1'b0;

    // load nine
    pre_a = 1'b1; pre_b = 1'b1;
    #1 chk("R8 nine at once", cnt_out, 4'd9);
    clr_a = 1'b1; clr_b = 1'b1;
    #1 chk("R8 set beats clear", cnt_out, 4'd9);
    @(negedge clk);
    pulse(0);
    chk("R8 edges ignored in set", cnt_out, 4'd9);
    clr_a = 1'b0; clr_b = 1'b0;
    #1 chk("R8 still nine", cnt_out, 4'd9);
    pre_a = 1'b0; pre_b = 1'b0;
    @(negedge clk);
    chk("R8 nine after release", cnt_out, 4'd9);
    pulse(0);
    chk("R5 nine wraps to zero", cnt_out, 4'd0);

    // split-symmetry link
    link_mode = 2'b10;
    hi = 0;
    for (int k = 1; k <= 20; k++) begin
      pulse(1);
      chk("R6 split-symmetry count", cnt_out, sym_exp(k));
      if (k <= 10 && cnt_out[0]) hi++;
    end
    chk("R6 duty five of ten", 4'(hi), 4'd5);
    pulse(0);
    chk("R6 cnt_a_in ignored", cnt_out, sym_exp(20));
    pulse(1); pulse(1); pulse(1);
    chk("R6 split-symmetry count", cnt_out, sym_exp(23));

    // reset mid-run
    rst_n = 1'b0;
    #1 chk("R1 reset mid-run", cnt_out, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 zero after reset", cnt_out, 4'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule